// File: doc/BRIEF.md
# Timer Interrupt Router with Legacy Line Takeover

This block sits between a bank of timer channels and a set of interrupt lines. Each timer delivers a one-cycle fire strobe when it expires. The router turns that strobe into activity on one interrupt line. The line is picked by the timer's route field. It is signalled either as a held level, backed by a per-timer status bit, or as a single-cycle pulse. Status bits are dropped by a clear request, by disabling the timer, or by disabling the whole block. A dropped status bit also releases the line.

Two lines normally carry interrupts from an external interval timer and an external real-time clock, and these pass through the router. When the legacy takeover bit is set, timer 0 and timer 1 claim those two lines whatever their route fields say. The external pass-through is then blocked, and an enable output tells the interval timer to stand down. When takeover ends, the interval timer is enabled again. The clock line then shows the clock level, which the router samples every cycle even while takeover is active.

Every input is sampled on the rising clock edge. The interrupt lines, status bits and interval-timer enable reflect it from the following cycle.

Top module: `tmr_irq_router`

## Requirements
- R1: During and directly after synchronous active-low reset, all interrupt lines are 0, all status bits are 0 and the interval-timer enable is 1.
- R2: A fire strobe on an enabled level-mode timer (mode bit 1) sets that timer's status bit and raises its routed line from the next cycle. The line stays high until the status is dropped.
- R3: A fire strobe on an enabled edge-mode timer (mode bit 0) gives a pulse on its routed line in the next cycle only. The pulse lasts exactly one cycle, and the status bit is left at 0.
- R4: A status-clear request, a low timer enable or a low global enable drops the timer's status bit and its line in the next cycle.
- R5: A timer's route field gives the line number it drives. A route value of N_LINES or more drives no line, but the status bit still behaves as in R2.
- R6: While takeover is active, timer 0 drives line 0 and timer 1 drives line 8, whatever their route fields hold. Timers 2 and up keep using their route fields.
- R7: When the takeover bit is set, the interval-timer enable goes low from the next cycle. The external interval-timer and clock inputs then no longer reach lines 0 and 8.
- R8: When the takeover bit is cleared, the interval-timer enable goes high from the next cycle. Line 8 then shows the latest sampled clock input level, and line 0 shows the interval-timer input.
- R9: Outside takeover, the interval-timer input appears on line 0 and the clock input on line 8, each delayed by one cycle.
- R10: A line shared by several sources is the OR of all level assertions, edge pulses and pass-through levels routed to it.
- R11: When a fire strobe and a status-clear request reach the same level-mode timer in the same cycle, the fire wins and the status bit is set. A fire strobe on a disabled timer, or while the global enable is low, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fire_i | input | N_TIMERS | One-cycle expiry strobe per timer |
| tmr_en_i | input | N_TIMERS | Per-timer interrupt enable |
| tmr_lvl_i | input | N_TIMERS | Per-timer mode: 1 level, 0 edge |
| tmr_route_i | input | N_TIMERS*ROUTE_W | Route fields, timer t at bits [t*ROUTE_W +: ROUTE_W] |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy line takeover request |
| stat_clr_i | input | N_TIMERS | Per-timer status-clear request |
| pit_irq_i | input | 1 | External interval-timer interrupt level |
| rtc_irq_i | input | 1 | External real-time clock interrupt level |
| irq_o | output | N_LINES | Interrupt lines |
| status_o | output | N_TIMERS | Level-mode status bits |
| pit_en_o | output | 1 | Interval-timer enable, low during takeover |

## Verification
A fire strobe and a status-clear request can reach the same timer in the same edge. The bench provokes this on a level-mode timer that already holds status, and expects the status and the line to stay high. A second case puts an edge pulse from one timer on a line that a level timer is releasing in that same cycle. There, the line must be high for exactly one more cycle and then fall. Both are judged at the ports, one cycle after the edge in which the inputs are sampled.

// File: rtl/irq_route_pkg.sv
// Package: shared mode encoding and helpers for the timer interrupt router.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_route_pkg;

    // Signalling mode of one timer, as carried on tmr_lvl_i.
    typedef enum logic {
        MODE_EDGE  = 1'b0,
        MODE_LEVEL = 1'b1
    } sig_mode_e;

    // Fixed lines taken over in legacy mode.
    localparam int unsigned TAKEOVER_LINE_A = 0;
    localparam int unsigned TAKEOVER_LINE_B = 8;

endpackage

// File: rtl/tmr_irq_chan.sv
// Module: tmr_irq_chan
// Per-timer signalling state. Holds the level status bit and the one-cycle
// edge pulse for one timer.
// Assumes: fire_i is a single-cycle strobe. The channel is live only while
// both its own enable and the global enable are high.
module tmr_irq_chan
    import irq_route_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic en_i,
    input  logic lvl_i,
    input  logic glb_en_i,
    input  logic clr_i,
    output logic status_o,
    output logic pulse_o,
    output logic active_o
);

    logic live;
    logic status_q;
    logic pulse_q;

    // Channel may act only when both enables are high.
    assign live = en_i & glb_en_i;

    // Status and pulse update: disable beats all, fire beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= 1'b0;
            pulse_q  <= 1'b0;
        end else begin
            pulse_q <= live & fire_i & (sig_mode_e'(lvl_i) == MODE_EDGE);
            if (!live) begin
                status_q <= 1'b0;
            end else if (fire_i && sig_mode_e'(lvl_i) == MODE_LEVEL) begin
                status_q <= 1'b1;
            end else if (fire_i || clr_i) begin
                status_q <= 1'b0;
            end
        end
    end

    assign status_o = status_q;
    assign pulse_o  = pulse_q;
    assign active_o = status_q | pulse_q;

    // R2 / R11: live level fire always leaves status set, even with clear
    a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && en_i && glb_en_i && lvl_i) |=> status_o);

    // R3: live edge fire gives a pulse and no status
    a_r3_edge_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && en_i && glb_en_i && !lvl_i) |=> (pulse_o && !status_o));

    // R4: a disabled channel holds neither status nor pulse
    a_r4_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i || !glb_en_i) |=> (!status_o && !pulse_o));

endmodule

// File: rtl/tmr_route_dec.sv
// Module: tmr_route_dec
// Turns each timer's route field into a one-hot line select. In legacy mode,
// timers 0 and 1 are forced onto the takeover lines.
// Assumes: N_LINES <= 2**ROUTE_W and N_LINES > TAKEOVER_LINE_B. Route values
// at or above N_LINES select nothing.
module tmr_route_dec
    import irq_route_pkg::*;
#(
    parameter int unsigned N_TIMERS = 4,
    parameter int unsigned N_LINES  = 24,
    parameter int unsigned ROUTE_W  = 5
) (
    input  logic [N_TIMERS*ROUTE_W-1:0] route_i,
    input  logic                        legacy_i,
    output logic [N_TIMERS*N_LINES-1:0] sel_o
);

    for (genvar t = 0; t < N_TIMERS; t++) begin : g_tmr
        logic [ROUTE_W-1:0] eff_route;
        logic               forced;
        logic [ROUTE_W-1:0] forced_line;

        // Pick a takeover line for timers 0 and 1 only.
        if (t == 0) begin : g_force_a
            assign forced      = legacy_i;
            assign forced_line = ROUTE_W'(TAKEOVER_LINE_A);
        end else if (t == 1) begin : g_force_b
            assign forced      = legacy_i;
            assign forced_line = ROUTE_W'(TAKEOVER_LINE_B);
        end else begin : g_free
            assign forced      = 1'b0;
            assign forced_line = '0;
        end

        // Effective route: forced line or configured field.
        assign eff_route = forced ? forced_line : route_i[t*ROUTE_W +: ROUTE_W];

        for (genvar k = 0; k < N_LINES; k++) begin : g_line
            // One select bit per (timer, line) pair.
            assign sel_o[t*N_LINES + k] = (eff_route == ROUTE_W'(k));
        end
    end

endmodule

// File: rtl/tmr_legacy_ctl.sv
// Module: tmr_legacy_ctl
// Samples the legacy bit and the external interval-timer and clock levels.
// Builds the pass-through line vector and the interval-timer enable.
// Assumes: external inputs are synchronous to clk. The clock level is sampled
// every cycle, so it is current when takeover ends.
module tmr_legacy_ctl
    import irq_route_pkg::*;
#(
    parameter int unsigned N_LINES = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               legacy_i,
    input  logic               pit_irq_i,
    input  logic               rtc_irq_i,
    output logic               legacy_o,
    output logic               pit_en_o,
    output logic [N_LINES-1:0] pass_o
);

    logic legacy_q;
    logic pit_q;
    logic rtc_q;

    // Sample mode bit and external levels each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            legacy_q <= 1'b0;
            pit_q    <= 1'b0;
            rtc_q    <= 1'b0;
        end else begin
            legacy_q <= legacy_i;
            pit_q    <= pit_irq_i;
            rtc_q    <= rtc_irq_i;
        end
    end

    assign legacy_o = legacy_q;
    assign pit_en_o = ~legacy_q;

    for (genvar k = 0; k < N_LINES; k++) begin : g_pass
        // Only the two takeover lines carry external levels.
        if (k == TAKEOVER_LINE_A) begin : g_pit
            assign pass_o[k] = ~legacy_q & pit_q;
        end else if (k == TAKEOVER_LINE_B) begin : g_rtc
            assign pass_o[k] = ~legacy_q & rtc_q;
        end else begin : g_none
            assign pass_o[k] = 1'b0;
        end
    end

    // R7: takeover blocks both external paths and disables the interval timer
    a_r7_block: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_i |=> (!pass_o[TAKEOVER_LINE_A] && !pass_o[TAKEOVER_LINE_B] && !pit_en_o));

    // R8: interval timer re-enabled outside takeover
    a_r8_pit_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !legacy_i |=> pit_en_o);

    // R9: interval-timer input passes to line 0 outside takeover
    a_r9_pit_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_i && pit_irq_i) |=> pass_o[TAKEOVER_LINE_A]);

    // R8 / R9: clock level reaches line 8 outside takeover
    a_r8_rtc_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!legacy_i && rtc_irq_i) |=> pass_o[TAKEOVER_LINE_B]);

endmodule

// File: rtl/tmr_irq_router.sv
// Module: tmr_irq_router (top)
// Routes timer fire strobes to interrupt lines in level or edge form, with a
// legacy mode that takes over the two fixed external lines.
// Assumes: N_LINES > 8 and N_LINES <= 2**ROUTE_W. All inputs are synchronous.
module tmr_irq_router
    import irq_route_pkg::*;
#(
    parameter int unsigned N_TIMERS = 4,
    parameter int unsigned N_LINES  = 24,
    parameter int unsigned ROUTE_W  = $clog2(N_LINES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_TIMERS-1:0]         fire_i,
    input  logic [N_TIMERS-1:0]         tmr_en_i,
    input  logic [N_TIMERS-1:0]         tmr_lvl_i,
    input  logic [N_TIMERS*ROUTE_W-1:0] tmr_route_i,
    input  logic                        glb_en_i,
    input  logic                        legacy_i,
    input  logic [N_TIMERS-1:0]         stat_clr_i,
    input  logic                        pit_irq_i,
    input  logic                        rtc_irq_i,
    output logic [N_LINES-1:0]          irq_o,
    output logic [N_TIMERS-1:0]         status_o,
    output logic                        pit_en_o
);

    localparam int unsigned SEL_W = N_TIMERS * N_LINES;

    logic [N_TIMERS-1:0] active;
    logic [N_TIMERS-1:0] pulse;
    logic [SEL_W-1:0]    sel;
    logic [N_LINES-1:0]  pass;
    logic                legacy_q;

    for (genvar t = 0; t < N_TIMERS; t++) begin : g_chan
        tmr_irq_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .fire_i   (fire_i[t]),
            .en_i     (tmr_en_i[t]),
            .lvl_i    (tmr_lvl_i[t]),
            .glb_en_i (glb_en_i),
            .clr_i    (stat_clr_i[t]),
            .status_o (status_o[t]),
            .pulse_o  (pulse[t]),
            .active_o (active[t])
        );
    end

    tmr_legacy_ctl #(
        .N_LINES (N_LINES)
    ) u_legacy (
        .clk       (clk),
        .rst_n     (rst_n),
        .legacy_i  (legacy_i),
        .pit_irq_i (pit_irq_i),
        .rtc_irq_i (rtc_irq_i),
        .legacy_o  (legacy_q),
        .pit_en_o  (pit_en_o),
        .pass_o    (pass)
    );

    tmr_route_dec #(
        .N_TIMERS (N_TIMERS),
        .N_LINES  (N_LINES),
        .ROUTE_W  (ROUTE_W)
    ) u_dec (
        .route_i  (tmr_route_i),
        .legacy_i (legacy_q),
        .sel_o    (sel)
    );

    // Merge pass-through levels with every timer routed to each line.
    always_comb begin
        irq_o = pass;
        for (int t = 0; t < N_TIMERS; t++) begin
            irq_o = irq_o | (sel[t*N_LINES +: N_LINES] & {N_LINES{active[t]}});
        end
    end

    // R3: an edge pulse never lasts two cycles without a second strobe
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse[0] && !fire_i[0]) |=> !pulse[0]);

endmodule

// File: tb/tb_tmr_irq_router.sv
module tb_tmr_irq_router;

    localparam int NT = 4;
    localparam int NL = 24;
    localparam int RW = 5;
    localparam time CLK_P = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NT-1:0]    fire, ten, tlvl, sclr;
    logic [NT*RW-1:0] troute;
    logic             glb, legacy, pit_in, rtc_in;
    logic [NL-1:0]    irq;
    logic [NT-1:0]    status;
    logic             pit_en;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_irq_router #(.N_TIMERS(NT), .N_LINES(NL), .ROUTE_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .tmr_en_i(ten),
        .tmr_lvl_i(tlvl), .tmr_route_i(troute), .glb_en_i(glb),
        .legacy_i(legacy), .stat_clr_i(sclr), .pit_irq_i(pit_in),
        .rtc_irq_i(rtc_in), .irq_o(irq), .status_o(status), .pit_en_o(pit_en)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [NL-1:0] ln(int k);
        return NL'(1) << k;
    endfunction

    task automatic set_route(int t, int v);
        troute[t*RW +: RW] = RW'(v);
    endtask

    task automatic fire1(int t);
        fire[t] = 1'b1;
        step();
        fire[t] = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; fire = '0; ten = '0; tlvl = '0; sclr = '0; troute = '0;
        glb = 1'b0; legacy = 1'b0; pit_in = 1'b0; rtc_in = 1'b0;
        step(); step();
        chk("R1 irq", 32'(irq), 0);
        chk("R1 status", 32'(status), 0);
        chk("R1 pit_en", 32'(pit_en), 1);
        rst_n = 1'b1;
        step();
        chk("R1 irq after release", 32'(irq), 0);
    endtask

    task automatic t_level();
        glb = 1'b1; ten[2] = 1'b1; tlvl[2] = 1'b1; set_route(2, 5);
        fire1(2);
        chk("R2 line set", 32'(irq), 32'(ln(5)));
        chk("R2 status set", 32'(status), 32'h4);
        step(); step(); step();
        chk("R2 line held", 32'(irq), 32'(ln(5)));
        sclr[2] = 1'b1; step(); sclr[2] = 1'b0;
        chk("R4 clear drops line", 32'(irq), 0);
        chk("R4 clear drops status", 32'(status), 0);
    endtask

    task automatic t_edge();
        ten[3] = 1'b1; tlvl[3] = 1'b0; set_route(3, 7);
        fire1(3);
        chk("R3 pulse", 32'(irq), 32'(ln(7)));
        chk("R3 no status", 32'(status), 0);
        step();
        chk("R3 pulse ends", 32'(irq), 0);
    endtask

    task automatic t_disable();
        fire1(2);
        ten[2] = 1'b0; step();
        chk("R4 timer disable", 32'({status, irq[5]}), 0);
        fire1(2);
        chk("R11 fire on disabled ignored", 32'({status, irq}), 0);
        ten[2] = 1'b1;
        fire1(2);
        chk("R2 refire", 32'(status[2]), 1);
        glb = 1'b0; step();
        chk("R4 global disable", 32'({status, irq}), 0);
        fire1(2);
        chk("R11 fire while global off ignored", 32'({status, irq}), 0);
        glb = 1'b1;
    endtask

    task automatic t_route();
        set_route(2, 30);
        fire1(2);
        chk("R5 out-of-range no line", 32'(irq), 0);
        chk("R5 out-of-range status", 32'(status), 32'h4);
        set_route(2, 23);
        step();
        chk("R5 reroute top line", 32'(irq), 32'(ln(23)));
        sclr[2] = 1'b1; step(); sclr[2] = 1'b0;
        chk("R4 clear after reroute", 32'(irq), 0);
    endtask

    task automatic t_shared_race();
        set_route(2, 5); set_route(3, 5);
        fire1(2);
        chk("R10 level on shared", 32'(irq), 32'(ln(5)));
        fire[2] = 1'b1; sclr[2] = 1'b1; step(); fire[2] = 1'b0; sclr[2] = 1'b0;
        chk("R11 fire beats clear", 32'(status), 32'h4);
        chk("R11 line stays", 32'(irq), 32'(ln(5)));
        sclr[2] = 1'b1; fire[3] = 1'b1; step(); sclr[2] = 1'b0; fire[3] = 1'b0;
        chk("R10 pulse keeps shared line", 32'(irq), 32'(ln(5)));
        chk("R10 level status gone", 32'(status), 0);
        step();
        chk("R10 shared line falls", 32'(irq), 0);
    endtask

    task automatic t_pass();
        pit_in = 1'b1; step();
        chk("R9 pit to line 0", 32'(irq), 32'(ln(0)));
        rtc_in = 1'b1; step();
        chk("R9 rtc to line 8", 32'(irq), 32'(ln(0) | ln(8)));
        pit_in = 1'b0; step();
        chk("R9 pit falls", 32'(irq), 32'(ln(8)));
    endtask

    task automatic t_legacy();
        pit_in = 1'b1;
        legacy = 1'b1; step();
        chk("R7 pit_en low", 32'(pit_en), 0);
        chk("R7 lines blocked", 32'(irq), 0);
        ten[0] = 1'b1; tlvl[0] = 1'b1; set_route(0, 3);
        fire1(0);
        chk("R6 timer0 on line 0", 32'(irq), 32'(ln(0)));
        ten[1] = 1'b1; tlvl[1] = 1'b0; set_route(1, 4);
        fire1(1);
        chk("R6 timer1 pulse on line 8", 32'(irq), 32'(ln(0) | ln(8)));
        set_route(2, 6); tlvl[2] = 1'b1;
        fire1(2);
        chk("R6 timer2 uses route", 32'(irq), 32'(ln(0) | ln(6)));
        sclr = 4'b0101; step(); sclr = '0;
        chk("R4 clear in legacy", 32'(irq), 0);
        rtc_in = 1'b0; step(); rtc_in = 1'b1; step();
        legacy = 1'b0; pit_in = 1'b0; step();
        chk("R8 pit_en high", 32'(pit_en), 1);
        chk("R8 line 8 restored, line 0 low", 32'(irq), 32'(ln(8)));
        fire1(0);
        chk("R5 timer0 back to route", 32'(irq), 32'(ln(3) | ln(8)));
    endtask

    initial begin
        #(CLK_P * 50000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_level();
        t_edge();
        t_disable();
        t_route();
        t_shared_race();
        t_pass();
        t_legacy();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule